// File: doc/BRIEF.md
# NAND Read Strobe Generator

This block drives the active-low read-enable strobe for a burst of asynchronous NAND data-out cycles and samples the 8-bit data bus once per byte. A start request loads a byte count and three cycle counts: how long the strobe stays low, how long it stays high between bytes, and how many clock edges after each falling edge the data bus is sampled. The sample point is counted independently of the low period. It may therefore fall after the strobe has risen again, inside the device's data hold window.

Each byte period lasts the low count plus the high count. If the sample delay is longer than that sum, the high phase is stretched so that the sample for a byte is always taken before the next falling edge. Every sampled byte is presented for one cycle with a valid pulse. The end of the burst is marked by a one-cycle done pulse, and busy drops in the same cycle.

Top module: `nand_rd_strobe`

## Requirements
- R1: After each falling edge, re_no stays low for lo_cnt_i clock cycles.
- R2: When cap_cnt_i <= lo_cnt_i + hi_cnt_i, re_no stays high for hi_cnt_i cycles before the next byte's falling edge, so each byte period is lo + hi cycles.
- R3: data_i is sampled at the cap_cnt_i-th rising clock edge after the edge that drove re_no low.
- R4: A capture delay larger than lo_cnt_i is supported: the sample is taken while re_no is high, and it belongs to the same byte.
- R5: When cap_cnt_i > lo_cnt_i + hi_cnt_i, the high phase is stretched. The byte period becomes cap_cnt_i cycles, and the next falling edge follows the sample edge.
- R6: re_no is high and busy_o is low after reset and after a burst ends. busy_o is high from the cycle after an accepted start until the final high phase completes.
- R7: done_o pulses for exactly one cycle, in the cycle after the final byte period ends. busy_o is low in that same cycle.
- R8: The counts and the byte count are sampled when a start is accepted (start_i high while busy_o is low). Input changes and start_i pulses during a burst have no effect.
- R9: A value of zero in lo_cnt_i, hi_cnt_i, cap_cnt_i or len_i is treated as one.
- R10: Each byte produces exactly one single-cycle vld_o pulse, in the cycle after its sample edge, with the sampled value on data_o. Bytes are delivered in read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request, accepted when idle |
| len_i | input | 8 | Bytes in the burst (0 means 1) |
| lo_cnt_i | input | 6 | Strobe-low cycles per byte |
| hi_cnt_i | input | 6 | Strobe-high cycles per byte |
| cap_cnt_i | input | 6 | Edges from falling strobe to sample point |
| data_i | input | 8 | NAND data bus |
| re_no | output | 1 | Read-enable strobe, active low |
| vld_o | output | 1 | Captured byte valid, one cycle |
| data_o | output | 8 | Captured byte |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst finished, one cycle |

## Verification
The bench drives the expected byte on data_i only during the single cycle before the required sample edge, and drives its complement in every other cycle. A design whose sample point is one edge early or late therefore returns inverted data. Sample delays are exercised below, between and beyond the low and high boundaries: a design that drops a late sample, or does not stretch the high phase, loses a byte, shows a short period, or captures the next byte's data. Zero counts, changes to the count inputs in the middle of a burst, and repeated start pulses check that the burst is not cut short, reloaded or restarted.

// File: rtl/nrs_pkg.sv
`timescale 1ns/1ps
package nrs_pkg;
  parameter int unsigned NRS_CNT_W  = 6;
  parameter int unsigned NRS_LEN_W  = 8;
  parameter int unsigned NRS_DATA_W = 8;
  typedef enum logic {RE_ON = 1'b0, RE_OFF = 1'b1} re_lvl_e;
endpackage

// File: rtl/nrs_cfg.sv
`timescale 1ns/1ps
module nrs_cfg #(
  parameter int unsigned CNT_W = nrs_pkg::NRS_CNT_W,
  parameter int unsigned LEN_W = nrs_pkg::NRS_LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned NCNT = 3;
  logic [NCNT-1:0][CNT_W-1:0] raw_w, cnt_q;

  assign raw_w = {cap_i, hi_i, lo_i};

  // zero counts become one (R9)
  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q[g] <= CNT_W'(1);
      else if (load_i) cnt_q[g] <= (raw_w[g] == '0) ? CNT_W'(1) : raw_w[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_o <= LEN_W'(1);
    else if (load_i) len_o <= (len_i == '0) ? LEN_W'(1) : len_i;
  end

  assign lo_o  = cnt_q[0];
  assign hi_o  = cnt_q[1];
  assign cap_o = cnt_q[2];

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(cnt_q) && $stable(len_o)));
endmodule

// File: rtl/nrs_timer.sv
`timescale 1ns/1ps
module nrs_timer #(
  parameter int unsigned CNT_W = nrs_pkg::NRS_CNT_W,
  parameter int unsigned LEN_W = nrs_pkg::NRS_LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             re_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             cap_hit_o
);
  import nrs_pkg::*;
  localparam int unsigned PW = CNT_W + 1;

  logic [PW-1:0]    sum_w, per_w, cap_w, edge_q;
  logic [LEN_W-1:0] byte_q;
  logic             last_w;

  assign cap_w  = PW'(cap_i);
  assign sum_w  = PW'(lo_i) + PW'(hi_i);
  // stretch the high phase when the sample lands past lo+hi (R5)
  assign per_w  = (cap_w > sum_w) ? cap_w : sum_w;
  assign last_w = (byte_q == len_i - LEN_W'(1));

  // edge_q = index of the coming edge, counted from the edge that lowered RE#
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_no  <= RE_OFF;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      edge_q <= '0;
      byte_q <= '0;
    end else if (accept_i) begin
      re_no  <= RE_ON;
      busy_o <= 1'b1;
      done_o <= 1'b0;
      edge_q <= PW'(1);
      byte_q <= '0;
    end else if (busy_o) begin
      done_o <= 1'b0;
      edge_q <= edge_q + PW'(1);
      if (edge_q == PW'(lo_i)) re_no <= RE_OFF;
      if (edge_q == per_w) begin
        if (last_w) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          re_no  <= RE_OFF;
        end else begin
          re_no  <= RE_ON;
          edge_q <= PW'(1);
          byte_q <= byte_q + LEN_W'(1);
        end
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign cap_hit_o = busy_o && (edge_q == cap_w);

  p_edge_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (edge_q != '0 && edge_q <= per_w));
  p_idle_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> re_no);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/nrs_capture.sv
`timescale 1ns/1ps
module nrs_capture #(
  parameter int unsigned DATA_W = nrs_pkg::NRS_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= hit_i;
      if (hit_i) data_o <= data_i;
    end
  end

  p_vld_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  p_vld_in_burst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(busy_i));
endmodule

// File: rtl/nand_rd_strobe.sv
`timescale 1ns/1ps
module nand_rd_strobe #(
  parameter int unsigned CNT_W  = nrs_pkg::NRS_CNT_W,
  parameter int unsigned LEN_W  = nrs_pkg::NRS_LEN_W,
  parameter int unsigned DATA_W = nrs_pkg::NRS_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  lo_cnt_i,
  input  logic [CNT_W-1:0]  hi_cnt_i,
  input  logic [CNT_W-1:0]  cap_cnt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              re_no,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             accept_w, hit_w;
  logic [CNT_W-1:0] lo_w, hi_w, cap_w;
  logic [LEN_W-1:0] len_w;

  assign accept_w = start_i && !busy_o;

  nrs_cfg #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
    .clk_i, .rst_ni, .load_i(accept_w), .busy_i(busy_o),
    .lo_i(lo_cnt_i), .hi_i(hi_cnt_i), .cap_i(cap_cnt_i), .len_i(len_i),
    .lo_o(lo_w), .hi_o(hi_w), .cap_o(cap_w), .len_o(len_w)
  );

  nrs_timer #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_tmr (
    .clk_i, .rst_ni, .accept_i(accept_w),
    .lo_i(lo_w), .hi_i(hi_w), .cap_i(cap_w), .len_i(len_w),
    .re_no, .busy_o, .done_o, .cap_hit_o(hit_w)
  );

  nrs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .hit_i(hit_w), .busy_i(busy_o), .data_i,
    .vld_o, .data_o
  );

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> busy_o || done_o);
endmodule

// File: tb/sim_nand_rd_strobe.sv
`timescale 1ns/1ps
module sim_nand_rd_strobe;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] len_i = '0;
  logic [5:0] lo_cnt_i = '0, hi_cnt_i = '0, cap_cnt_i = '0;
  logic [7:0] data_i = '0;
  logic       re_no, vld_o, busy_o, done_o;
  logic [7:0] data_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  nand_rd_strobe u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] bval(input int b, input int seed);
    return 8'(seed * 37 + b * 11 + 5);
  endfunction

  // one burst; expected waveform derived from requirements
  task automatic run_burst(input int len, input int lo, input int hi, input int cap,
                           input int seed, input bit disturb, input string req);
    int le = (len == 0) ? 1 : len;
    int lo_e = (lo == 0) ? 1 : lo;
    int hi_e = (hi == 0) ? 1 : hi;
    int ca_e = (cap == 0) ? 1 : cap;
    int per = (ca_e > lo_e + hi_e) ? ca_e : lo_e + hi_e;
    int last = le * per + 2;
    @(negedge clk_i);
    len_i = 8'(len); lo_cnt_i = 6'(lo); hi_cnt_i = 6'(hi); cap_cnt_i = 6'(cap);
    start_i = 1'b1;
    for (int j = 1; j <= last; j++) begin
      int b, t, vb;
      bit exp_re, exp_busy, exp_done, exp_vld;
      @(negedge clk_i);
      start_i = disturb && (j % 3 == 0);
      if (disturb) begin
        lo_cnt_i = 6'(j + 7); hi_cnt_i = 6'(j * 3); cap_cnt_i = 6'(j);
        len_i = 8'(j + 2);
      end
      b = (j - 1) / per;
      t = (j - 1) % per;
      exp_busy = (j <= le * per);
      exp_done = (j == le * per + 1);
      exp_re   = !exp_busy || (t >= lo_e);
      vb = (j - 1 - ca_e) / per;
      exp_vld = (j - 1 >= ca_e) && ((j - 1 - ca_e) % per == 0) && (vb < le);
      chk(re_no == exp_re, {req, " re_no"}, re_no, exp_re);
      chk(busy_o == exp_busy, {req, " busy R6"}, busy_o, exp_busy);
      chk(done_o == exp_done, {req, " done R7"}, done_o, exp_done);
      chk(vld_o == exp_vld, {req, " vld R10"}, vld_o, exp_vld);
      if (exp_vld)
        chk(data_o == bval(vb, seed), {req, " data R3 R10"}, data_o, bval(vb, seed));
      // drive the byte only in the cycle before the required sample edge
      data_i = (exp_busy && t == ca_e - 1) ? bval(b, seed) : ~bval(b, seed);
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(re_no == 1'b1, "R6 reset re_no", re_no, 1);
    chk(busy_o == 1'b0, "R6 reset busy", busy_o, 0);
    chk(vld_o == 1'b0, "R10 reset vld", vld_o, 0);
    chk(done_o == 1'b0, "R7 reset done", done_o, 0);
  endtask

  task automatic t_basic;      run_burst(4, 3, 2, 2, 1, 0, "R1 R2 R3 basic"); endtask
  task automatic t_cap_at_lo;  run_burst(3, 2, 3, 2, 2, 0, "R3 cap=lo");     endtask
  task automatic t_late_cap;   run_burst(3, 2, 3, 4, 3, 0, "R4 late cap");   endtask
  task automatic t_cap_edge;   run_burst(2, 2, 2, 4, 4, 0, "R4 cap=lo+hi");  endtask
  task automatic t_stretch;    run_burst(3, 2, 1, 7, 5, 0, "R5 stretch");    endtask
  task automatic t_zero;       run_burst(0, 0, 0, 0, 6, 0, "R9 zeros");      endtask
  task automatic t_zero_mix;   run_burst(2, 0, 3, 0, 7, 0, "R9 lo cap zero"); endtask
  task automatic t_disturb;    run_burst(3, 3, 2, 4, 8, 1, "R8 disturb");    endtask

  task automatic t_idle_after;
    repeat (3) begin
      @(negedge clk_i);
      chk(re_no == 1'b1 && busy_o == 1'b0, "R6 idle after burst", re_no, 1);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_cap_at_lo();
    t_late_cap();
    t_cap_edge();
    t_stretch();
    t_zero();
    t_zero_mix();
    t_disturb();
    t_idle_after();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule